// File: doc/BRIEF.md
# TDM ADC Frame Receiver

This block sits on the receiving end of a converter that pushes its conversion results out on its own. The converter is the bus master. It supplies the bit clock and a data-ready marker, and it drives one, two or eight serial data lanes. The receiver runs directly on that bit clock. It finds the start of each frame, shifts the lanes in MSB first, and counts 32-bit slots. It then presents each completed channel word on a parallel output, together with a one-cycle valid strobe and a channel number.

The lane count is set by a static two-bit selection. The selection is read only at a frame start, so one frame always uses one layout. With one lane, a frame is 256 bits long and carries channels 0 to 7 in order. With two lanes, lane 0 carries channels 0 to 3 and lane 1 carries channels 4 to 7, at 128 bits per lane. With eight lanes, lane i carries channel i, at 32 bits per lane. Faster output rates need more lanes, and each added lane shortens the frame.

Two sticky flags report framing faults. One flag is set when a marker cuts a frame short. The other is set when the bit clock keeps running after a frame has completed with no new marker. A synchronous clear input resets both flags.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is held low at a clock edge, out_valid, err_short and err_over read 0 after that edge.
- R2: Data bits are ignored until the first rising edge of frame_mark after reset. A rising edge is frame_mark high at a clock edge after being low at the previous edge. The bit sampled at that same edge is bit 31 of slot 0. Every bit is sampled on the rising clock edge, and each slot is shifted in MSB first.
- R3: With lane_sel = 00, a frame is 256 bits on sdata[0], and slot k is reported as channel k for k = 0..7.
- R4: With lane_sel = 01, a frame is 128 bits per lane. Slot k of sdata[0] is channel k, and slot k of sdata[1] is channel k+4. The two words are reported in that order on consecutive cycles.
- R5: With lane_sel = 10 or 11, a frame is 32 bits per lane, and sdata[i] carries channel i. The eight words are reported in ascending channel order on eight consecutive cycles.
- R6: Suppose the last bit of a slot is sampled at clock edge t. Then the first word of that slot group is valid after edge t+1, and each following word is valid one edge later.
- R7: A change of lane_sel in the middle of a frame does not affect that frame. It takes effect at the next marker edge.
- R8: If a marker edge arrives while a frame is active and its per-lane bit count has not been reached, err_short goes to 1 after that edge and stays set. The unfinished slot is dropped, and the new frame starts with that bit.
- R9: If a frame has reached its full per-lane bit count and a clock edge arrives without a marker edge, err_over goes to 1 after that edge and stays set. Further bits are then ignored until the next marker edge.
- R10: err_clr high at a clock edge clears both flags after that edge. A flag that is being set at the same edge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the converter; all logic uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_mark | input | 1 | Data-ready marker from the converter; its rising edge starts a frame |
| lane_sel | input | 2 | Lane layout: 00 one lane, 01 two lanes, 10 or 11 eight lanes |
| sdata | input | 8 | Serial data lanes; unused lanes are ignored |
| err_clr | input | 1 | Synchronous clear of both error flags |
| out_valid | output | 1 | One-cycle strobe for each reported channel word |
| out_data | output | 32 | Channel word |
| out_chan | output | 3 | Channel number of out_data |
| err_short | output | 1 | Sticky flag: a frame was cut short by a marker |
| err_over | output | 1 | Sticky flag: the clock ran past a complete frame |

## Verification
The in-design assertions assume two things about the inputs. First, the bit clock only runs while data or idle bits are being delivered. Second, successive slot completions are at least eight clock cycles apart, which holds for every layout because a slot is 32 bits long. The stimulus keeps within these limits. It sends frames back to back, each with a marker that is high for the first bit only, and it leaves the clock running idle only before the first marker or when an overrun is wanted on purpose. It also covers a mid-frame change of lane_sel, a truncated frame whose marker coincides with err_clr, and a known eight-lane frame, so that lane-to-channel mapping and ordering are checked against fixed words.

// File: rtl/tdmrx_pkg.sv
// Shared constants, the lane-layout type and helpers for the TDM frame receiver.
package tdmrx_pkg;
    localparam int unsigned NCH        = 8;
    localparam int unsigned SLOT_W     = 32;
    localparam int unsigned NLANE      = 8;
    localparam int unsigned CH_W       = $clog2(NCH);
    localparam int unsigned SLOT_BITS  = $clog2(SLOT_W);
    localparam int unsigned FRAME_BITS = NCH * SLOT_W;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int unsigned REM_W      = $clog2(NCH + 1);

    typedef enum logic [1:0] {
        LAYOUT_ONE   = 2'b00,
        LAYOUT_TWO   = 2'b01,
        LAYOUT_EIGHT = 2'b10,
        LAYOUT_EIGHT_ALT = 2'b11
    } lane_cfg_e;

    // Number of active lanes for a layout.
    function automatic int unsigned lane_count(lane_cfg_e c);
        case (c)
            LAYOUT_ONE: return 1;
            LAYOUT_TWO: return 2;
            default:    return NLANE;
        endcase
    endfunction

    // Bits per lane in one frame.
    function automatic logic [CNT_W-1:0] frame_len(lane_cfg_e c);
        return CNT_W'(FRAME_BITS / lane_count(c));
    endfunction

    // log2 of the slots carried per lane, used to turn a lane number into a channel base.
    function automatic logic [1:0] lane_shift(lane_cfg_e c);
        case (c)
            LAYOUT_ONE: return 2'd3;
            LAYOUT_TWO: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/tdmrx_lane_shifter.sv
// Per-lane serial-to-parallel shift registers.
// Each lane shifts on every bit-clock edge without any control. The word presented
// is the last W bits including the bit sampled this cycle, so it is valid exactly
// when the frame controller signals that a slot ends on this edge.
module tdmrx_lane_shifter #(
    parameter int unsigned NL = 8,
    parameter int unsigned W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NL-1:0]         sdata,
    output logic [NL-1:0][W-1:0]  word
);
    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [W-2:0] hist;
        // Keep the previous W-1 bits of this lane, newest at bit 0.
        always_ff @(posedge clk) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[W-3:0], sdata[l]};
        end
        assign word[l] = {hist, sdata[l]};
    end
endmodule

// File: rtl/tdmrx_frame_ctrl.sv
// Frame alignment, bit counting, layout latching and error flags.
// Assumes the marker is sampled on the bit clock. A rising edge of the marker
// starts a frame, and the bit sampled on that edge is the first bit of slot 0.
module tdmrx_frame_ctrl
    import tdmrx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_mark,
    input  lane_cfg_e       cfg_in,
    input  logic            err_clr,
    output logic            capture,
    output logic [CH_W-1:0] slot,
    output lane_cfg_e       cfg_q,
    output logic            err_short,
    output logic            err_over
);
    logic             mark_q, active, mark_edge, take, short_hit, over_hit;
    logic [CNT_W-1:0] cnt, idx, flen;

    assign mark_edge = frame_mark & ~mark_q;
    assign flen      = frame_len(cfg_q);
    assign take      = mark_edge | (active & (cnt != flen));
    assign idx       = mark_edge ? '0 : cnt;
    assign capture   = take & (idx[SLOT_BITS-1:0] == SLOT_BITS'(SLOT_W - 1));
    assign slot      = CH_W'(idx >> SLOT_BITS);
    assign short_hit = mark_edge & active & (cnt != flen);
    assign over_hit  = ~mark_edge & active & (cnt == flen);

    // Remember the marker level; reset high so a level held through reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mark_q <= 1'b1;
        else        mark_q <= frame_mark;
    end

    // Frame state: restart on a marker edge, stop on overrun, otherwise count bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            cfg_q  <= LAYOUT_ONE;
        end else if (mark_edge) begin
            active <= 1'b1;
            cnt    <= CNT_W'(1);
            cfg_q  <= cfg_in;
        end else if (over_hit) begin
            active <= 1'b0;
        end else if (take) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Sticky error flags; a set has priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_short <= 1'b0;
            err_over  <= 1'b0;
        end else begin
            if (short_hit)    err_short <= 1'b1;
            else if (err_clr) err_short <= 1'b0;
            if (over_hit)     err_over  <= 1'b1;
            else if (err_clr) err_over  <= 1'b0;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != '0) && (cnt <= frame_len(cfg_q)));
    // R8
    short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_short && !err_clr) |=> err_short);
    // R9
    over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_over && !err_clr) |=> err_over);
endmodule

// File: rtl/tdmrx_slot_emitter.sv
// Holds the words of one slot group and reports them one per cycle.
// Lanes are reported in ascending lane order, which is ascending channel order.
// Assumes slot groups complete at least NCH cycles apart, which is guaranteed
// because each slot is SLOT_W bits long.
module tdmrx_slot_emitter
    import tdmrx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture,
    input  logic [CH_W-1:0]              slot,
    input  lane_cfg_e                    cfg,
    input  logic [NLANE-1:0][SLOT_W-1:0] words,
    output logic                         out_valid,
    output logic [SLOT_W-1:0]            out_data,
    output logic [CH_W-1:0]              out_chan
);
    logic [NLANE-1:0][SLOT_W-1:0] hold;
    logic [REM_W-1:0]             rem;
    logic [CH_W-1:0]              ptr, slot_q;
    logic [1:0]                   sh_q;

    // Load a completed slot group, then step through its lanes one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            rem       <= '0;
            ptr       <= '0;
            slot_q    <= '0;
            sh_q      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_chan  <= '0;
        end else if (capture) begin
            hold      <= words;
            rem       <= REM_W'(lane_count(cfg));
            ptr       <= '0;
            slot_q    <= slot;
            sh_q      <= lane_shift(cfg);
            out_valid <= 1'b0;
        end else if (rem != '0) begin
            out_valid <= 1'b1;
            out_data  <= hold[ptr];
            out_chan  <= (ptr << sh_q) | slot_q;
            ptr       <= ptr + CH_W'(1);
            rem       <= rem - REM_W'(1);
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (rem == '0));
    // R5
    chan_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid || (out_chan > $past(out_chan))));
endmodule

// File: rtl/tdm_frame_rx.sv
// Top of the slave-side TDM frame receiver. Runs entirely on the converter's
// bit clock. Frame control finds slot boundaries, the shifters collect lane bits,
// and the emitter reports each channel word with a strobe and a channel number.
module tdm_frame_rx
    import tdmrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_mark,
    input  logic [1:0]        lane_sel,
    input  logic [NLANE-1:0]  sdata,
    input  logic              err_clr,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic              err_short,
    output logic              err_over
);
    logic                         capture;
    logic [CH_W-1:0]              slot;
    lane_cfg_e                    cfg_q;
    logic [NLANE-1:0][SLOT_W-1:0] words;

    tdmrx_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_mark(frame_mark),
        .cfg_in    (lane_cfg_e'(lane_sel)),
        .err_clr   (err_clr),
        .capture   (capture),
        .slot      (slot),
        .cfg_q     (cfg_q),
        .err_short (err_short),
        .err_over  (err_over)
    );

    tdmrx_lane_shifter #(.NL(NLANE), .W(SLOT_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .sdata(sdata),
        .word (words)
    );

    tdmrx_slot_emitter u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .slot     (slot),
        .cfg      (cfg_q),
        .words    (words),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_chan (out_chan)
    );
endmodule

// File: tb/tb_tdm_frame_rx.sv
module tb_tdm_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_mark = 1'b0;
    logic [1:0]  lane_sel = 2'b00;
    logic [7:0]  sdata = 8'h00;
    logic        err_clr = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [2:0]  out_chan;
    logic        err_short, err_over;

    tdm_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .frame_mark(frame_mark), .lane_sel(lane_sel),
        .sdata(sdata), .err_clr(err_clr), .out_valid(out_valid), .out_data(out_data),
        .out_chan(out_chan), .err_short(err_short), .err_over(err_over)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    words_seen = 0;
    string cur_req = "R1";
    logic [31:0] got_word [8];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int due; int ch; logic [31:0] d; } exp_t;
    exp_t eq[$];
    bit   lq[8][$];
    int   cyc = 0;
    bit   m_prev, m_act, m_sh, m_ov;
    int   m_cnt, m_cfg;

    function automatic int nl_of(int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 8;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_prev = 1; m_act = 0; m_cnt = 0; m_cfg = 0; m_sh = 0; m_ov = 0;
            eq.delete();
            for (int l = 0; l < 8; l++) lq[l].delete();
        end else begin
            bit edge_m, set_s, set_o;
            int flen;
            edge_m = frame_mark && !m_prev;
            m_prev = frame_mark;
            set_s = 0; set_o = 0;
            flen = 256 / nl_of(m_cfg);
            if (edge_m) begin
                if (m_act && m_cnt != flen) set_s = 1;
                m_act = 1; m_cnt = 0; m_cfg = int'(lane_sel);
                for (int l = 0; l < 8; l++) lq[l].delete();
            end else if (m_act && m_cnt == flen) begin
                set_o = 1; m_act = 0;
            end
            flen = 256 / nl_of(m_cfg);
            if (m_act && m_cnt < flen) begin
                int nl;
                nl = nl_of(m_cfg);
                for (int l = 0; l < nl; l++) lq[l].push_back(sdata[l]);
                m_cnt++;
                if (lq[0].size() == 32) begin
                    for (int l = 0; l < nl; l++) begin
                        exp_t e;
                        e.d = '0;
                        for (int b = 0; b < 32; b++) e.d = {e.d[30:0], 1'(lq[l].pop_front())};
                        e.ch  = l * (8 / nl) + (m_cnt - 1) / 32;
                        e.due = cyc + 1 + l;
                        eq.push_back(e);
                    end
                end
            end
            if (set_s) m_sh = 1; else if (err_clr) m_sh = 0;
            if (set_o) m_ov = 1; else if (err_clr) m_ov = 0;
        end
    end

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            bit ev;
            ev = (eq.size() > 0) && (eq[0].due == cyc);
            check(out_valid == ev, cur_req, "out_valid", out_valid, ev);
            if (ev && out_valid) begin
                check(out_data == eq[0].d && int'(out_chan) == eq[0].ch, cur_req,
                      "word/chan", {out_chan, out_data}, {eq[0].ch[2:0], eq[0].d});
            end
            if (ev) void'(eq.pop_front());
            check(err_short == m_sh, "R8", "err_short", err_short, m_sh);
            check(err_over == m_ov, "R9", "err_over", err_over, m_ov);
        end
        if (out_valid) begin
            words_seen++;
            got_word[out_chan] = out_data;
        end
    end

    // Watchdog: counts as a failed check and still reports the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] known_word(int l);
        return 32'h1357_9BDF ^ {4{8'(l * 37 + 5)}};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_mark = 1'b0; err_clr = 1'b0; sdata = 8'($urandom);
        end
    endtask

    task automatic send_frame(input logic [1:0] code, input int nbits,
                              input logic [1:0] mid, input logic clr_mark);
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            frame_mark = (b == 0);
            lane_sel   = (b < nbits / 2) ? code : mid;
            err_clr    = clr_mark && (b == 0);
            sdata      = 8'($urandom);
        end
    endtask

    task automatic send_known();
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            frame_mark = (b == 0);
            lane_sel   = 2'b10;
            err_clr    = 1'b0;
            for (int l = 0; l < 8; l++) sdata[l] = known_word(l)[31 - b];
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(err_short == 1'b0, "R1", "err_short in reset", err_short, 0);
        check(err_over == 1'b0,  "R1", "err_over in reset", err_over, 0);
        rst_n = 1'b1;

        // R2: bits without a marker edge are ignored
        cur_req = "R2";
        idle(40);
        check(words_seen == 0, "R2", "words before marker", words_seen, 0);

        // R3 / R7: one-lane frames, selection changed mid-frame
        cur_req = "R7";
        send_frame(2'b00, 256, 2'b01, 1'b0);
        cur_req = "R3";
        send_frame(2'b00, 256, 2'b00, 1'b0);
        // R4 / R7: two-lane frames, selection changed mid-frame
        cur_req = "R4";
        send_frame(2'b01, 128, 2'b10, 1'b0);
        send_frame(2'b01, 128, 2'b01, 1'b0);
        // R5 / R6: eight-lane frames back to back, both codes
        cur_req = "R5";
        send_frame(2'b10, 32, 2'b10, 1'b0);
        send_frame(2'b11, 32, 2'b11, 1'b0);
        send_frame(2'b10, 32, 2'b10, 1'b0);
        // R8 / R10: truncated frame, its cutting marker coincides with a clear
        cur_req = "R8";
        send_frame(2'b00, 100, 2'b00, 1'b0);
        send_frame(2'b00, 256, 2'b00, 1'b1);
        check(err_short == 1'b1, "R10", "set wins over clear", err_short, 1);
        // R5: known words on eight lanes, then the clock keeps running (R9)
        cur_req = "R5";
        send_known();
        idle(12);
        for (int l = 0; l < 8; l++)
            check(got_word[l] == known_word(l), "R5", "lane to channel word",
                  got_word[l], known_word(l));
        check(err_over == 1'b1, "R9", "overrun flag", err_over, 1);
        check(err_short == 1'b1, "R8", "short flag sticky", err_short, 1);
        // R10: clear both flags
        cur_req = "R10";
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check(err_short == 1'b0, "R10", "short cleared", err_short, 0);
        check(err_over == 1'b0,  "R10", "over cleared", err_over, 0);
        // R9: after an overrun, bits stay ignored until a marker edge
        cur_req = "R9";
        idle(40);
        check(words_seen == 75, "R9", "total words", words_seen, 75);
        check(err_over == 1'b0, "R9", "no new overrun while idle", err_over, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule